// File: doc/BRIEF.md
# I2C Master Bus Status Tracker

This block watches the two wires of an I2C bus on behalf of a master controller and keeps three status flags, which it presents as an 8-bit read-only status word. It resynchronises the SCL and SDA pin levels to the system clock and detects START and STOP conditions from them. From these it keeps a bus-busy flag. In acknowledge slots it records the bit that the addressed device returned. While the master drives data bits, it compares each driven bit with the level seen on the wire and latches a transmit-error flag when they differ.

The master's shift engine tells the block when it is driving a data bit (`tx_drive`), when the current bit is the acknowledge slot (`tx_ack_slot`), and the bit value it wants on the wire (`tx_bit`). The block returns the pull-down request for the SDA pad (`sda_low_o`). A transmit error does not alter that request, so the byte in progress finishes on the wire. A write strobe from the control register clears the error. Dropping the enable input clears every flag.

Top module: `i2c_bus_status`

## Requirements
- R1: `status_o` carries bus-busy in bit 0, the captured acknowledge in bit 1 and the transmit error in bit 2. Bits 7 to 3 always read 0, and the word is 8'h00 after reset.
- R2: A START (SDA falling while SCL is high) sets bit 0. The flag is visible on the third rising clock edge after the pin change.
- R3: A STOP (SDA rising while SCL is high) clears bit 0, with the same three-edge latency.
- R4: On each SCL rising edge while `tx_ack_slot` is 1, bit 1 takes the sampled SDA level: 0 for an ACK, 1 for a NACK.
- R5: On an SCL rising edge while `tx_drive` is 1 and `tx_ack_slot` is 0, bit 2 sets if the sampled SDA level differs from `tx_bit`. A mismatch while `tx_drive` is 0 has no effect.
- R6: A one-cycle `ctrl_wr` pulse clears bit 2 on the next clock edge. If a mismatch sets the flag in the same cycle, the set wins and bit 2 stays 1.
- R7: While `enable` is 0, bits 2 to 0 are 0 one clock after the drop, and START conditions are ignored.
- R8: `sda_low_o` is 1 exactly when `enable` and `tx_drive` are 1 and `tx_bit` is 0. This holds whatever the value of the transmit-error flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Interface enable; 0 clears and holds all flags |
| ctrl_wr | input | 1 | Control-register write strobe; clears the transmit error |
| tx_drive | input | 1 | Master is driving the current data bit |
| tx_ack_slot | input | 1 | Current bit is an acknowledge slot |
| tx_bit | input | 1 | Bit value the master wants on SDA |
| scl_pin | input | 1 | SCL pad level (asynchronous) |
| sda_pin | input | 1 | SDA pad level (asynchronous) |
| sda_low_o | output | 1 | Request to pull SDA low |
| status_o | output | 8 | Status word {5'b0, txerr, ack, busy} |

## Verification
Each pin change passes through two synchroniser flops and one flag register. A flag that a pin event moves is therefore due on the third rising clock edge after the change, and the bench samples one time unit after that edge. The effects of `ctrl_wr` and `enable` are registered once, so they are checked one edge after the strobe. `sda_low_o` is combinational and is checked in the same cycle its inputs change. For the set-over-clear case, the bench raises `ctrl_wr` exactly in the cycle where the detected SCL edge is registered.

// File: rtl/i2cst_pkg.sv
package i2cst_pkg;
    localparam int STATUS_W = 8;
    localparam int FLAG_W   = 3;
    localparam int SYNC_STAGES = 2;

    typedef struct packed {
        logic txerr;
        logic ack;
        logic busy;
    } flags_t;

    localparam flags_t FLAGS_CLEAR = '{txerr: 1'b0, ack: 1'b0, busy: 1'b0};

    function automatic logic [STATUS_W-1:0] to_word(flags_t f);
        return {{(STATUS_W-FLAG_W){1'b0}}, f};
    endfunction
endpackage

// File: rtl/i2cst_sync.sv
module i2cst_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q,
    output logic q_prev
);
    logic [STAGES-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= RST_VAL;
                else if (g == 0) chain[g] <= d;
                else chain[g] <= chain[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) q_prev <= RST_VAL;
        else     q_prev <= chain[STAGES-1];
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/i2cst_edge.sv
module i2cst_edge (
    input  logic scl_now,
    input  logic scl_was,
    input  logic sda_now,
    input  logic sda_was,
    output logic start_evt,
    output logic stop_evt,
    output logic scl_rise
);
    logic scl_held_high;

    always_comb begin
        scl_held_high = scl_now & scl_was;
        start_evt     = scl_held_high & sda_was & ~sda_now;
        stop_evt      = scl_held_high & ~sda_was & sda_now;
        scl_rise      = scl_now & ~scl_was;
    end
endmodule

// File: rtl/i2cst_flags.sv
module i2cst_flags
    import i2cst_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   enable,
    input  logic   ctrl_wr,
    input  logic   start_evt,
    input  logic   stop_evt,
    input  logic   scl_rise,
    input  logic   sda_lvl,
    input  logic   tx_drive,
    input  logic   tx_ack_slot,
    input  logic   tx_bit,
    output flags_t flags
);
    logic ack_evt;
    logic mismatch_evt;

    always_comb begin
        ack_evt      = scl_rise & tx_ack_slot;
        mismatch_evt = scl_rise & tx_drive & ~tx_ack_slot & (sda_lvl != tx_bit);
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            flags <= FLAGS_CLEAR;
        end else begin
            if (start_evt)     flags.busy <= 1'b1;
            else if (stop_evt) flags.busy <= 1'b0;

            if (ack_evt) flags.ack <= sda_lvl;

            if (mismatch_evt) flags.txerr <= 1'b1;
            else if (ctrl_wr) flags.txerr <= 1'b0;
        end
    end

    a_r2_start_sets_busy: assert property (@(posedge clk) disable iff (rst)
        (enable && start_evt) |=> flags.busy);

    a_r3_stop_clears_busy: assert property (@(posedge clk) disable iff (rst)
        (enable && stop_evt) |=> !flags.busy);

    a_r4_ack_captured: assert property (@(posedge clk) disable iff (rst)
        (enable && ack_evt) |=> (flags.ack == $past(sda_lvl)));

    a_r5_mismatch_sets: assert property (@(posedge clk) disable iff (rst)
        (enable && mismatch_evt) |=> flags.txerr);

    a_r6_write_clears: assert property (@(posedge clk) disable iff (rst)
        (enable && ctrl_wr && !mismatch_evt) |=> !flags.txerr);

    a_r7_disable_clears: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (flags == FLAGS_CLEAR));
endmodule

// File: rtl/i2c_bus_status.sv
module i2c_bus_status
    import i2cst_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                enable,
    input  logic                ctrl_wr,
    input  logic                tx_drive,
    input  logic                tx_ack_slot,
    input  logic                tx_bit,
    input  logic                scl_pin,
    input  logic                sda_pin,
    output logic                sda_low_o,
    output logic [STATUS_W-1:0] status_o
);
    localparam int NPINS = 2;
    localparam int SCL_IDX = 0;
    localparam int SDA_IDX = 1;

    logic [NPINS-1:0] pin_raw;
    logic [NPINS-1:0] pin_now;
    logic [NPINS-1:0] pin_was;
    logic             start_evt;
    logic             stop_evt;
    logic             scl_rise;
    flags_t           flags;

    assign pin_raw[SCL_IDX] = scl_pin;
    assign pin_raw[SDA_IDX] = sda_pin;

    genvar p;
    generate
        for (p = 0; p < NPINS; p++) begin : g_pin
            i2cst_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
                .clk    (clk),
                .rst    (rst),
                .d      (pin_raw[p]),
                .q      (pin_now[p]),
                .q_prev (pin_was[p])
            );
        end
    endgenerate

    i2cst_edge u_edge (
        .scl_now   (pin_now[SCL_IDX]),
        .scl_was   (pin_was[SCL_IDX]),
        .sda_now   (pin_now[SDA_IDX]),
        .sda_was   (pin_was[SDA_IDX]),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .scl_rise  (scl_rise)
    );

    i2cst_flags u_flags (
        .clk         (clk),
        .rst         (rst),
        .enable      (enable),
        .ctrl_wr     (ctrl_wr),
        .start_evt   (start_evt),
        .stop_evt    (stop_evt),
        .scl_rise    (scl_rise),
        .sda_lvl     (pin_now[SDA_IDX]),
        .tx_drive    (tx_drive),
        .tx_ack_slot (tx_ack_slot),
        .tx_bit      (tx_bit),
        .flags       (flags)
    );

    // Pad request depends only on the transmit phase, never on the error flag
    assign sda_low_o = enable & tx_drive & ~tx_bit;
    assign status_o  = to_word(flags);

    // R8: an error rising with steady drive inputs leaves the pad request unchanged
    a_r8_drive_kept: assert property (@(posedge clk) disable iff (rst)
        ($rose(flags.txerr) && $stable(enable) && $stable(tx_drive) && $stable(tx_bit))
        |-> $stable(sda_low_o));

    a_r1_upper_zero: assert property (@(posedge clk) disable iff (rst)
        $rose(flags.busy) |-> (status_o[0] && status_o[STATUS_W-1:FLAG_W] == '0));
endmodule

// File: tb/i2c_bus_status_bench.sv
module i2c_bus_status_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LAT = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enable = 1'b0;
    logic       ctrl_wr = 1'b0;
    logic       tx_drive = 1'b0;
    logic       tx_ack_slot = 1'b0;
    logic       tx_bit = 1'b1;
    logic       scl_pin = 1'b1;
    logic       sda_pin = 1'b1;
    logic       sda_low_o;
    logic [7:0] status_o;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_bus_status u_i2c_bus_status (
        .clk         (clk),
        .rst         (rst),
        .enable      (enable),
        .ctrl_wr     (ctrl_wr),
        .tx_drive    (tx_drive),
        .tx_ack_slot (tx_ack_slot),
        .tx_bit      (tx_bit),
        .scl_pin     (scl_pin),
        .sda_pin     (sda_pin),
        .sda_low_o   (sda_low_o),
        .status_o    (status_o)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic scl_pulse_low_high();
        scl_pin = 1'b0;
        step(LAT + 1);
        scl_pin = 1'b1;
        step(LAT);
    endtask

    task automatic t_reset();
        check("R1 reset word", status_o, 8'h00);
    endtask

    task automatic t_start();
        enable = 1'b1;
        step(2);
        sda_pin = 1'b0;
        step(LAT - 1);
        check("R2 not before third edge", status_o, 8'h00);
        step(1);
        check("R2 start sets busy", status_o, 8'h01);
    endtask

    task automatic t_match_and_mismatch();
        scl_pin = 1'b0;
        step(LAT + 1);
        tx_drive = 1'b1;
        tx_bit = 1'b0;
        #1;
        check("R8 pull low for 0", {7'b0, sda_low_o}, 8'h01);
        scl_pin = 1'b1;
        step(LAT);
        check("R5 matching bit no error", status_o, 8'h01);
        scl_pin = 1'b0;
        step(LAT + 1);
        tx_bit = 1'b1;
        #1;
        check("R8 release for 1", {7'b0, sda_low_o}, 8'h00);
        scl_pin = 1'b1;
        step(LAT);
        check("R5 mismatch sets error", status_o, 8'h05);
        tx_bit = 1'b0;
        #1;
        check("R8 drive continues after error", {7'b0, sda_low_o}, 8'h01);
        tx_bit = 1'b1;
        #1;
        check("R8 drive follows bit after error", {7'b0, sda_low_o}, 8'h00);
    endtask

    task automatic t_clear();
        ctrl_wr = 1'b1;
        step(1);
        ctrl_wr = 1'b0;
        check("R6 write clears error", status_o, 8'h01);
    endtask

    task automatic t_released();
        scl_pin = 1'b0;
        step(LAT + 1);
        tx_drive = 1'b0;
        tx_bit = 1'b1;
        scl_pin = 1'b1;
        step(LAT);
        check("R5 released bit ignored", status_o, 8'h01);
    endtask

    task automatic t_ack();
        scl_pin = 1'b0;
        step(LAT + 1);
        tx_ack_slot = 1'b1;
        tx_drive = 1'b1;
        tx_bit = 1'b0;
        sda_pin = 1'b1;
        step(LAT);
        scl_pin = 1'b1;
        step(LAT);
        check("R4 NACK captured, ack slot not compared", status_o, 8'h03);
        scl_pin = 1'b0;
        step(LAT + 1);
        sda_pin = 1'b0;
        step(LAT);
        scl_pin = 1'b1;
        step(LAT);
        check("R4 ACK captured", status_o, 8'h01);
        tx_ack_slot = 1'b0;
    endtask

    task automatic t_priority();
        scl_pin = 1'b0;
        step(LAT + 1);
        tx_drive = 1'b1;
        tx_bit = 1'b1;
        scl_pin = 1'b1;
        step(2);
        ctrl_wr = 1'b1;
        step(1);
        ctrl_wr = 1'b0;
        check("R6 set wins over write", status_o, 8'h05);
        ctrl_wr = 1'b1;
        step(1);
        ctrl_wr = 1'b0;
        check("R6 later write clears", status_o, 8'h01);
        tx_drive = 1'b0;
    endtask

    task automatic t_stop();
        sda_pin = 1'b1;
        step(LAT - 1);
        check("R3 not before third edge", status_o, 8'h01);
        step(1);
        check("R3 stop clears busy", status_o, 8'h00);
    endtask

    task automatic t_disable();
        sda_pin = 1'b0;
        step(LAT);
        check("R2 second start", status_o, 8'h01);
        enable = 1'b0;
        step(1);
        check("R7 disable clears flags", status_o, 8'h00);
        sda_pin = 1'b1;
        step(LAT + 1);
        sda_pin = 1'b0;
        step(LAT + 1);
        check("R7 start ignored while disabled", status_o, 8'h00);
        tx_drive = 1'b1;
        tx_bit = 1'b0;
        #1;
        check("R8 no pull while disabled", {7'b0, sda_low_o}, 8'h00);
        tx_drive = 1'b0;
    endtask

    initial begin
        fork
            begin
                step(4);
                rst = 1'b0;
                step(1);
                t_reset();
                t_start();
                t_match_and_mismatch();
                t_clear();
                t_released();
                t_ack();
                t_priority();
                t_stop();
                t_disable();
            end
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_errors++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule